// File: doc/BRIEF.md
# Distributed Match Bitmap Loader

This block prepares a linear chain of processing cells for a bit-parallel longest-common-subsequence computation. Each cell owns one row of a character-match bitmap: one bit per possible character code. The bit is set only at the code of the string character assigned to that cell. A second, complementary bitmap is kept beside it. The block fills both bitmaps before any comparison work starts.

A pulse on `load_start` opens a loading window. The characters of the first string then enter at the head of the chain, qualified by `x_vld`, and travel one cell per clock. Every cell counts the valid characters that pass it. Cell `c` (counting from 0 at the head) keeps the character that arrives as its (c+1)-th, so cell 0 holds the first character, cell 1 the second, and so on. The window closes once every cell holds a character.

All cells then sweep their 2^CODE_W bitmap addresses together, in ascending order, one address per clock. The sweep writes 1 at the held code and 0 elsewhere, and writes the inverse into the complementary row. When the sweep ends, `map_ready` rises. A downstream stage can then present any code on `qry_code` and read one match bit per cell on `hit_vec`, and the complement on `miss_vec`.

Top module: `lcs_match_loader`

## Requirements
- R1: After reset, `map_ready` is 0, `hit_vec` is all zeros and `miss_vec` is all ones for every `qry_code`.
- R2: A cycle with `load_start` high starts a new load, and `map_ready` is 0 in the cycle that follows.
- R3: Cell c (bit c of `hit_vec`, bit 0 at the chain head) takes the (c+1)-th character presented with `x_vld` high after the most recent `load_start`. Idle cycles between characters do not change which character a cell takes.
- R4: The load ignores the following: characters presented with `x_vld` low, characters presented in the `load_start` cycle itself, and valid characters beyond the NCELLS-th.
- R5: Once `map_ready` is 1, `hit_vec[c]` is 1 exactly when `qry_code` equals the character held by cell c, and `miss_vec` is the bitwise inverse of `hit_vec`.
- R6: A `load_start` pulse at any time restarts loading. Characters taken before it are discarded, and the first valid character after it goes to cell 0.
- R7: The sweep visits addresses in ascending order, one per clock. When characters arrive on back-to-back cycles starting right after the `load_start` cycle, `map_ready` rises exactly 2*NCELLS + 2^CODE_W clock edges after the edge that sampled `load_start`, whatever the character values.
- R8: Once `map_ready` is 1, it stays 1 and the bitmaps stay unchanged until the next `load_start`. `x_vld` activity in that state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_start | input | 1 | Pulse that opens (or reopens) the loading window |
| x_chr | input | CODE_W | Character code entering the chain head |
| x_vld | input | 1 | Qualifies `x_chr` during loading |
| qry_code | input | CODE_W | Code whose bitmap column is read out |
| hit_vec | output | NCELLS | Match bit of each cell for `qry_code` |
| miss_vec | output | NCELLS | Complement-bitmap bit of each cell for `qry_code` |
| map_ready | output | 1 | Both bitmaps complete; computation may begin |

## Verification
The bench reads every one of the 256 bitmap columns after each load. A cell that latched a neighbour's character, or that swapped M and MN, shows up as a wrong column. Character sets place codes at 0 and 255, so a sweep that stops one address short or starts one address late leaves an edge column wrong. Idle gaps, garbage on `x_chr` while `x_vld` is low, and surplus characters catch a cell that counts clock steps instead of arrivals, or that takes a late character. Restarts both mid-load and mid-sweep would expose stale counters or stale capture flags. The exact `map_ready` edge count on gap-free loads of different content catches an off-by-one in the phase hand-off.

// File: rtl/lcsmap_pkg.sv
// Shared types for the match bitmap loader.
package lcsmap_pkg;

    // Phase of the loader: idle, character loading, bitmap sweep, complete.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_SWEEP = 2'd2,
        PH_DONE  = 2'd3
    } ldr_phase_t;

endpackage

// File: rtl/lcsmap_sweep_ctrl.sv
// Phase sequencer shared by all cells.
// Moves from loading to the address sweep once every cell holds a character.
// Then steps one address per clock from 0 to the top address, and then reports completion.
// Assumes: load_start may arrive in any phase and always wins.
module lcsmap_sweep_ctrl
    import lcsmap_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_start,
    input  logic                all_got,
    output ldr_phase_t          phase,
    output logic [CODE_W-1:0]   sweep_addr,
    output logic                sweep_en,
    output logic                loading,
    output logic                map_ready
);

    localparam logic [CODE_W-1:0] ADDR_MAX = {CODE_W{1'b1}};

    // Phase register and sweep address counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            sweep_addr <= '0;
        end else if (load_start) begin
            phase      <= PH_LOAD;
            sweep_addr <= '0;
        end else begin
            case (phase)
                PH_LOAD: begin
                    if (all_got) begin
                        phase      <= PH_SWEEP;
                        sweep_addr <= '0;
                    end
                end
                PH_SWEEP: begin
                    if (sweep_addr == ADDR_MAX) begin
                        phase <= PH_DONE;
                    end else begin
                        sweep_addr <= sweep_addr + 1'b1;
                    end
                end
                default: begin
                    phase <= phase;
                end
            endcase
        end
    end

    // Phase decodes used by the cells and the port.
    always_comb begin
        loading   = (phase == PH_LOAD);
        sweep_en  = (phase == PH_SWEEP);
        map_ready = (phase == PH_DONE);
    end

endmodule

// File: rtl/lcsmap_cell.sv
// One cell of the chain.
// Counts the valid characters that pass it and keeps the one whose arrival index equals its own index.
// During the sweep it rewrites its match row and complement row at the broadcast address.
// Assumes: in_vld is already gated to the loading phase by the chain.
module lcsmap_cell #(
    parameter int CODE_W   = 8,
    parameter int NCELLS   = 8,
    parameter int CELL_IDX = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                in_vld,
    input  logic [CODE_W-1:0]   in_chr,
    input  logic                sweep_en,
    input  logic [CODE_W-1:0]   sweep_addr,
    input  logic [CODE_W-1:0]   qry_code,
    output logic                got,
    output logic                hit,
    output logic                miss
);

    localparam int MAPSZ = 1 << CODE_W;
    localparam int CW    = $clog2(NCELLS + 1);
    localparam logic [CW-1:0] MY_SLOT = CW'(CELL_IDX);

    logic [CW-1:0]      arr_cnt;
    logic [CODE_W-1:0]  held_chr;
    logic [MAPSZ-1:0]   m_row;
    logic [MAPSZ-1:0]   mn_row;
    logic               mark;

    // Arrival counting and capture of this cell's character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_cnt  <= '0;
            got      <= 1'b0;
            held_chr <= '0;
        end else if (clear) begin
            arr_cnt <= '0;
            got     <= 1'b0;
        end else if (in_vld && !got) begin
            if (arr_cnt == MY_SLOT) begin
                held_chr <= in_chr;
                got      <= 1'b1;
            end else begin
                arr_cnt <= arr_cnt + 1'b1;
            end
        end
    end

    // Set bit for the address being swept.
    always_comb begin
        mark = (sweep_addr == held_chr);
    end

    // Sweep write into the match row and its complement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_row  <= '0;
            mn_row <= '1;
        end else if (sweep_en) begin
            m_row[sweep_addr]  <= mark;
            mn_row[sweep_addr] <= !mark;
        end
    end

    // Column readout for the requested code.
    always_comb begin
        hit  = m_row[qry_code];
        miss = mn_row[qry_code];
    end

endmodule

// File: rtl/lcs_match_loader.sv
// Top of the match bitmap loader.
// Carries the first string down a registered character lane, one cell per clock.
// Holds NCELLS cells and the shared sweep sequencer.
// Assumes: exactly NCELLS characters are supplied per load; extras are ignored.
module lcs_match_loader
    import lcsmap_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int NCELLS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_start,
    input  logic [CODE_W-1:0]   x_chr,
    input  logic                x_vld,
    input  logic [CODE_W-1:0]   qry_code,
    output logic [NCELLS-1:0]   hit_vec,
    output logic [NCELLS-1:0]   miss_vec,
    output logic                map_ready
);

    ldr_phase_t         phase;
    logic [CODE_W-1:0]  sweep_addr;
    logic               sweep_en;
    logic               loading;
    logic               all_got;
    logic [NCELLS-1:0]  got;
    logic [NCELLS-1:0]  lane_vld;
    logic [CODE_W-1:0]  lane_chr [NCELLS];

    lcsmap_sweep_ctrl #(
        .CODE_W (CODE_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_start (load_start),
        .all_got    (all_got),
        .phase      (phase),
        .sweep_addr (sweep_addr),
        .sweep_en   (sweep_en),
        .loading    (loading),
        .map_ready  (map_ready)
    );

    // Lane head: characters accepted only inside the loading window.
    always_comb begin
        lane_vld[0] = x_vld && loading && !load_start;
        lane_chr[0] = x_chr;
        all_got     = &got;
    end

    // Registered lane stages between neighbouring cells.
    for (genvar s = 1; s < NCELLS; s++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_vld[s] <= 1'b0;
                lane_chr[s] <= '0;
            end else begin
                lane_vld[s] <= lane_vld[s-1] && loading && !load_start;
                lane_chr[s] <= lane_chr[s-1];
            end
        end
    end

    // One cell per character position.
    for (genvar c = 0; c < NCELLS; c++) begin : g_cell
        lcsmap_cell #(
            .CODE_W   (CODE_W),
            .NCELLS   (NCELLS),
            .CELL_IDX (c)
        ) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear      (load_start),
            .in_vld     (lane_vld[c]),
            .in_chr     (lane_chr[c]),
            .sweep_en   (sweep_en),
            .sweep_addr (sweep_addr),
            .qry_code   (qry_code),
            .got        (got[c]),
            .hit        (hit_vec[c]),
            .miss       (miss_vec[c])
        );
    end

endmodule

// File: rtl/lcs_match_loader_chk.sv
// Property checker for the match bitmap loader, attached by bind.
module lcs_match_loader_chk
    import lcsmap_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int NCELLS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_start,
    input  logic [CODE_W-1:0]   qry_code,
    input  logic [NCELLS-1:0]   hit_vec,
    input  logic [NCELLS-1:0]   miss_vec,
    input  logic                map_ready,
    input  ldr_phase_t          phase,
    input  logic [CODE_W-1:0]   sweep_addr,
    input  logic                all_got
);

    // R1
    reset_clears_ready_chk: assert property (@(posedge clk)
        !rst_n |=> !map_ready);

    // R2
    start_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_start |=> !map_ready);

    // R3
    load_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SWEEP && $past(phase) == PH_LOAD) |-> $past(all_got));

    // R5
    map_complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        map_ready |-> ((hit_vec ^ miss_vec) == {NCELLS{1'b1}}));

    // R7
    sweep_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SWEEP && $past(phase) == PH_SWEEP && !$past(load_start))
        |-> (sweep_addr == CODE_W'($past(sweep_addr) + 1'b1)));

    // R7
    ready_after_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(map_ready) |-> ($past(phase) == PH_SWEEP && $past(sweep_addr) == {CODE_W{1'b1}}));

    // R8
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (map_ready && !load_start) |=> map_ready);

    // R8
    map_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (map_ready && !load_start) |=> (!$stable(qry_code) || $stable(hit_vec)));

endmodule

bind lcs_match_loader lcs_match_loader_chk #(
    .CODE_W (CODE_W),
    .NCELLS (NCELLS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_start (load_start),
    .qry_code   (qry_code),
    .hit_vec    (hit_vec),
    .miss_vec   (miss_vec),
    .map_ready  (map_ready),
    .phase      (phase),
    .sweep_addr (sweep_addr),
    .all_got    (all_got)
);

// File: tb/lcs_match_loader_tb.sv
module lcs_match_loader_tb;

    localparam int CODE_W = 8;
    localparam int NC     = 8;
    localparam int CLK_PERIOD = 10;
    localparam int NCODES = 1 << CODE_W;
    localparam int FULL_TIME = 2 * NC + NCODES;
    localparam int NVEC = 4;

    // Stimulus table: character k of a vector sits in bits [8k+7:8k];
    // gap bit k inserts one idle cycle (garbage code, x_vld low) before character k.
    localparam logic [63:0] VEC_CHR [NVEC] = '{
        64'h10_FF_00_62_63_63_62_61,
        64'h41_41_41_41_41_41_41_41,
        64'hFF_FE_FD_FC_03_02_01_00,
        64'h7E_FF_00_00_A5_5A_A5_5A
    };
    localparam logic [7:0] VEC_GAP [NVEC] = '{8'h00, 8'hA5, 8'hFF, 8'h42};
    localparam int VEC_EXTRA [NVEC] = '{2, 0, 3, 1};

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               load_start = 1'b0;
    logic [CODE_W-1:0]  x_chr = '0;
    logic               x_vld = 1'b0;
    logic [CODE_W-1:0]  qry_code = '0;
    logic [NC-1:0]      hit_vec;
    logic [NC-1:0]      miss_vec;
    logic               map_ready;

    int n_chk = 0;
    int n_fail = 0;
    int since_start = 0;
    logic [CODE_W-1:0] exp_c [NC];

    lcs_match_loader #(.CODE_W(CODE_W), .NCELLS(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_start(load_start),
        .x_chr(x_chr), .x_vld(x_vld), .qry_code(qry_code),
        .hit_vec(hit_vec), .miss_vec(miss_vec), .map_ready(map_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // One clock edge; inputs change and outputs are sampled at the falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        since_start++;
    endtask

    task automatic start_pulse();
        load_start = 1'b1;
        x_vld = 1'b1;
        x_chr = 8'hC3;
        tick();
        load_start = 1'b0;
        x_vld = 1'b0;
        since_start = 0;
    endtask

    task automatic feed(input logic [63:0] chars, input logic [7:0] gaps, input int extra);
        for (int k = 0; k < NC; k++) begin
            if (gaps[k]) begin
                x_vld = 1'b0;
                x_chr = 8'h99;
                tick();
            end
            x_vld = 1'b1;
            x_chr = chars[8*k +: 8];
            exp_c[k] = chars[8*k +: 8];
            tick();
        end
        for (int e = 0; e < extra; e++) begin
            x_vld = 1'b1;
            x_chr = 8'h33 + 8'(e);
            tick();
        end
        x_vld = 1'b0;
        x_chr = 8'h5C;
    endtask

    task automatic wait_ready(output int edges);
        int lim = 0;
        while (!map_ready && lim < 2000) begin
            tick();
            lim++;
        end
        edges = since_start;
        check(map_ready == 1'b1, "R7", "ready within bound", 32'(map_ready), 32'd1);
    endtask

    // Reads every column and compares with the expected characters (R3, R5).
    task automatic check_map(input string req);
        for (int q = 0; q < NCODES; q++) begin
            logic [NC-1:0] eh;
            qry_code = q[CODE_W-1:0];
            #1;
            for (int c = 0; c < NC; c++) eh[c] = (exp_c[c] == q[CODE_W-1:0]);
            check(hit_vec == eh && miss_vec == ~eh, req, "bitmap column",
                  {8'(q), 8'(hit_vec), 8'(miss_vec), 8'h0}, {8'(q), 8'(eh), 8'(~eh), 8'h0});
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin : main
        int edges;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        check(map_ready == 1'b0, "R1", "ready after reset", 32'(map_ready), 32'd0);
        foreach (VEC_GAP[i]) begin
            qry_code = (i == 0) ? 8'h00 : (i == 1) ? 8'h4D : 8'hFF;
            #1;
            check(hit_vec == '0 && miss_vec == '1, "R1", "reset bitmap",
                  {hit_vec, miss_vec}, {8'h00, 8'hFF});
        end

        // Table walk: R3, R4, R5, R7
        for (int v = 0; v < NVEC; v++) begin
            start_pulse();
            check(map_ready == 1'b0, "R2", "ready low after start", 32'(map_ready), 32'd0);
            feed(VEC_CHR[v], VEC_GAP[v], VEC_EXTRA[v]);
            wait_ready(edges);
            if (VEC_GAP[v] == 8'h00)
                check(edges == FULL_TIME, "R7", "fixed load time", 32'(edges), 32'(FULL_TIME));
            check_map("R3_R4_R5");
        end

        // R8: valid characters while ready are ignored
        for (int k = 0; k < 10; k++) begin
            x_vld = 1'b1;
            x_chr = 8'(8'h20 + k);
            tick();
        end
        x_vld = 1'b0;
        repeat (20) tick();
        check(map_ready == 1'b1, "R8", "ready holds", 32'(map_ready), 32'd1);
        check_map("R8");

        // R6: restart in the middle of loading
        start_pulse();
        feed(64'h0, 8'h00, 0);
        start_pulse();
        feed(64'h11_22_33_44_55_66_77_88, 8'h00, 0);
        wait_ready(edges);
        check(edges == FULL_TIME, "R7", "fixed time, other content", 32'(edges), 32'(FULL_TIME));
        check_map("R6");

        // R6: restart in the middle of the sweep
        start_pulse();
        feed(64'hAA_AA_AA_AA_AA_AA_AA_AA, 8'h00, 0);
        repeat (50) tick();
        check(map_ready == 1'b0, "R6", "still sweeping", 32'(map_ready), 32'd0);
        start_pulse();
        check(map_ready == 1'b0, "R2", "ready low after restart", 32'(map_ready), 32'd0);
        feed(64'h01_FE_01_FE_80_7F_80_7F, 8'h10, 0);
        wait_ready(edges);
        check_map("R6");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule